// File: doc/BRIEF.md
# Load/Store Port Request Sequencer

This block sits between a local controller and one handshake-based load/store port of a memory subsystem, on the side that issues requests. The controller hands over a single command (a start strobe, a load-or-store select, an address and, for stores, the write data). The sequencer then runs the whole port conversation. It waits until the port is free, raises the matching request line together with a qualified address, and waits for the port to accept or refuse that address. For a load it waits for the returned data. For a store it sends the data as a single-cycle pulse once the address is accepted, then waits for the port to go idle.

Completion is never assumed. The address stays presented and unchanged for as long as the port reports itself busy. When the request is finished, the controller sees a one-cycle done pulse that carries either the load data or an exception flag. A kill input abandons whatever is in flight and returns the port lines to their idle levels at once.

Address and data widths are parameters. An option selects whether the address and store-data buses are forced to zero when they are not qualified.

Top module: `ldst_req_seq`

## Requirements
- R1: While a request is open, exactly one of `port_ld_req_o` and `port_st_req_o` is high, selected by the command's `cmd_store_i` (1 = store, 0 = load). Both lines are never high together.
- R2: A request line rises only after a clock edge at which `port_busy_i` was sampled low. A command accepted while the port is busy waits until busy is low.
- R3: `port_addr_vld_o` rises together with the request line, carrying the captured command address on `port_addr_o`. Both stay asserted and unchanged until the request ends, which covers every cycle in which the port is busy for that request.
- R4: If `port_addr_exc_i` is sampled while the address awaits acceptance, the request ends. On the next cycle `done_o` is high with `exc_o` = 1 and `rdata_o` = 0. No store data pulse is issued, so memory is left untouched.
- R5: For a load accepted by `port_addr_ack_i`, the sequencer waits any number of cycles for `port_ld_vld_i`. It captures `port_ld_data_i` at that edge and raises `done_o` on the next cycle, with that data on `rdata_o` and `exc_o` = 0.
- R6: For a store, `port_st_vld_o` is high for exactly one cycle, namely the cycle right after the edge that sampled `port_addr_ack_i`. In that cycle `port_st_data_o` equals the command's store data, and it is never issued before the acknowledge.
- R7: After the store pulse, the request stays open until `port_busy_i` is sampled low. `done_o` follows one cycle later with `exc_o` = 0.
- R8: A high `kill_i` at a clock edge returns the sequencer to idle. On the next cycle all port request, valid and store lines are low, `cmd_ready_o` is high, and no `done_o` pulse is produced for the abandoned request.
- R9: `cmd_start_i` is taken only while `cmd_ready_o` is high, which is in the idle state. A start strobe during a request changes neither the request kind, the address, the store data nor the result.
- R10: `done_o` is a single-cycle pulse during which every port request and valid line is low. After reset, all outputs are low except `cmd_ready_o`, which is high.
- R11: Cycle timing from the edge that samples the start strobe, with no extra busy and an acknowledge after D idle cycles: an exception gives done D+3 edges later; a load whose data follows the acknowledge after L idle cycles gives done D+L+4 edges later; a store whose port drops busy one cycle after the pulse gives done D+5 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| kill_i | input | 1 | Abandon the current request and return to idle |
| cmd_start_i | input | 1 | Command strobe, taken only when ready |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_wdata_i | input | DATA_W | Command store data |
| cmd_ready_o | output | 1 | Sequencer idle and able to take a command |
| done_o | output | 1 | One-cycle completion pulse |
| exc_o | output | 1 | Request was refused (valid with done_o) |
| rdata_o | output | DATA_W | Load result (valid with done_o) |
| port_ld_req_o | output | 1 | Load request to the port |
| port_st_req_o | output | 1 | Store request to the port |
| port_addr_vld_o | output | 1 | Address qualifier |
| port_addr_o | output | ADDR_W | Request address |
| port_st_vld_o | output | 1 | One-cycle store data qualifier |
| port_st_data_o | output | DATA_W | Store data |
| port_busy_i | input | 1 | Port has a request in progress |
| port_addr_ack_i | input | 1 | One-cycle address acceptance |
| port_addr_exc_i | input | 1 | One-cycle address refusal |
| port_ld_vld_i | input | 1 | One-cycle load data qualifier |
| port_ld_data_i | input | DATA_W | Load data |

## Verification
The bench sweeps every word of a small memory model with several acknowledge and load-data delays. It compares each completion cycle against the arithmetic latency, so a sequencer that leaves a request a cycle early or late, or that drops the address before busy falls, shows up as a latency mismatch or a hold violation. Refused stores are followed by loads of the same word: a design that pulsed store data before acceptance would corrupt memory, and one that ignored the refusal would hang. A port held busy by another party, stray start strobes during a request, and a kill in the middle of a long load wait are aimed at designs that issue into a busy port, re-capture the command, or emit a late done for an abandoned request.

// File: rtl/ldst_seq_pkg.sv
package ldst_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE    = 3'd0,
      SQ_ARM     = 3'd1,
      SQ_ADDR    = 3'd2,
      SQ_LDWAIT  = 3'd3,
      SQ_STPULSE = 3'd4,
      SQ_STDRAIN = 3'd5,
      SQ_DONE    = 3'd6
   } seq_state_e;

   // States in which a request is presented on the port
   function automatic logic state_has_req(input seq_state_e s);
      return (s == SQ_ADDR) || (s == SQ_LDWAIT) ||
             (s == SQ_STPULSE) || (s == SQ_STDRAIN);
   endfunction

endpackage

// File: rtl/ldst_seq_cmd_hold.sv
module ldst_seq_cmd_hold #(
   parameter int ADDR_W = 48,
   parameter int DATA_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              take_i,
   input  logic              store_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              store_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         store_o <= 1'b0;
         addr_o  <= '0;
         data_o  <= '0;
      end else if (take_i) begin
         store_o <= store_i;
         addr_o  <= addr_i;
         data_o  <= data_i;
      end
   end

endmodule

// File: rtl/ldst_seq_fsm.sv
module ldst_seq_fsm
   import ldst_seq_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       kill_i,
   input  logic       start_i,
   input  logic       store_i,
   input  logic       busy_i,
   input  logic       ack_i,
   input  logic       exc_i,
   input  logic       ld_vld_i,
   output seq_state_e state_o,
   output logic       take_cmd_o,
   output logic       take_ld_o,
   output logic       take_exc_o
);

   seq_state_e nxt;

   always_comb begin
      nxt        = state_o;
      take_cmd_o = 1'b0;
      take_ld_o  = 1'b0;
      take_exc_o = 1'b0;
      unique case (state_o)
         SQ_IDLE: begin
            if (start_i) begin
               nxt        = SQ_ARM;
               take_cmd_o = 1'b1;
            end
         end
         SQ_ARM: begin
            if (!busy_i) nxt = SQ_ADDR;
         end
         SQ_ADDR: begin
            if (exc_i) begin
               nxt        = SQ_DONE;
               take_exc_o = 1'b1;
            end else if (ack_i) begin
               nxt = store_i ? SQ_STPULSE : SQ_LDWAIT;
            end
         end
         SQ_LDWAIT: begin
            if (ld_vld_i) begin
               nxt       = SQ_DONE;
               take_ld_o = 1'b1;
            end
         end
         SQ_STPULSE: nxt = SQ_STDRAIN;
         SQ_STDRAIN: begin
            if (!busy_i) nxt = SQ_DONE;
         end
         SQ_DONE: nxt = SQ_IDLE;
         default: nxt = SQ_IDLE;
      endcase
      if (kill_i) begin
         nxt        = SQ_IDLE;
         take_cmd_o = 1'b0;
         take_ld_o  = 1'b0;
         take_exc_o = 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) state_o <= SQ_IDLE;
      else         state_o <= nxt;
   end

endmodule

// File: rtl/ldst_seq_result.sv
module ldst_seq_result #(
   parameter int DATA_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              take_ld_i,
   input  logic              take_exc_i,
   input  logic [DATA_W-1:0] ld_data_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              exc_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rdata_o <= '0;
         exc_o   <= 1'b0;
      end else if (clear_i) begin
         rdata_o <= '0;
         exc_o   <= 1'b0;
      end else begin
         if (take_ld_i)  rdata_o <= ld_data_i;
         if (take_exc_i) exc_o   <= 1'b1;
      end
   end

endmodule

// File: rtl/ldst_req_seq.sv
module ldst_req_seq
   import ldst_seq_pkg::*;
#(
   parameter int ADDR_W         = 48,
   parameter int DATA_W         = 64,
   parameter bit ZERO_IDLE_DATA = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              kill_i,
   input  logic              cmd_start_i,
   input  logic              cmd_store_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [DATA_W-1:0] cmd_wdata_i,
   output logic              cmd_ready_o,
   output logic              done_o,
   output logic              exc_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              port_ld_req_o,
   output logic              port_st_req_o,
   output logic              port_addr_vld_o,
   output logic [ADDR_W-1:0] port_addr_o,
   output logic              port_st_vld_o,
   output logic [DATA_W-1:0] port_st_data_o,
   input  logic              port_busy_i,
   input  logic              port_addr_ack_i,
   input  logic              port_addr_exc_i,
   input  logic              port_ld_vld_i,
   input  logic [DATA_W-1:0] port_ld_data_i
);

   localparam int STATE_W = $bits(seq_state_e);

   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ldst_req_seq: ADDR_W must lie in 1..64");
   end
   if (DATA_W < 1 || DATA_W > 512) begin : g_bad_data_w
      $error("ldst_req_seq: DATA_W must lie in 1..512");
   end
   if (STATE_W != 3) begin : g_bad_state_w
      $error("ldst_req_seq: state encoding width changed");
   end

   seq_state_e        state;
   logic              take_cmd, take_ld, take_exc;
   logic              hold_store;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;
   logic              req_open;

   ldst_seq_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .kill_i     (kill_i),
      .start_i    (cmd_start_i),
      .store_i    (hold_store),
      .busy_i     (port_busy_i),
      .ack_i      (port_addr_ack_i),
      .exc_i      (port_addr_exc_i),
      .ld_vld_i   (port_ld_vld_i),
      .state_o    (state),
      .take_cmd_o (take_cmd),
      .take_ld_o  (take_ld),
      .take_exc_o (take_exc)
   );

   ldst_seq_cmd_hold #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .take_i  (take_cmd),
      .store_i (cmd_store_i),
      .addr_i  (cmd_addr_i),
      .data_i  (cmd_wdata_i),
      .store_o (hold_store),
      .addr_o  (hold_addr),
      .data_o  (hold_data)
   );

   ldst_seq_result #(
      .DATA_W (DATA_W)
   ) u_res (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (take_cmd | kill_i),
      .take_ld_i  (take_ld),
      .take_exc_i (take_exc),
      .ld_data_i  (port_ld_data_i),
      .rdata_o    (rdata_o),
      .exc_o      (exc_o)
   );

   assign req_open        = state_has_req(state);
   assign cmd_ready_o     = (state == SQ_IDLE);
   assign done_o          = (state == SQ_DONE);
   assign port_ld_req_o   = req_open & ~hold_store;
   assign port_st_req_o   = req_open &  hold_store;
   assign port_addr_vld_o = req_open;
   assign port_st_vld_o   = (state == SQ_STPULSE);

   if (ZERO_IDLE_DATA) begin : g_gated_bus
      assign port_addr_o    = req_open      ? hold_addr : '0;
      assign port_st_data_o = port_st_vld_o ? hold_data : '0;
   end else begin : g_raw_bus
      assign port_addr_o    = hold_addr;
      assign port_st_data_o = hold_data;
   end

endmodule

// File: rtl/ldst_req_seq_chk.sv
module ldst_req_seq_chk #(
   parameter int ADDR_W = 48,
   parameter int DATA_W = 64
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              kill_i,
   input logic              cmd_ready_o,
   input logic              done_o,
   input logic              exc_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic              port_ld_req_o,
   input logic              port_st_req_o,
   input logic              port_addr_vld_o,
   input logic [ADDR_W-1:0] port_addr_o,
   input logic              port_st_vld_o,
   input logic              port_busy_i,
   input logic              port_addr_ack_i,
   input logic              port_addr_exc_i,
   input logic              port_ld_vld_i,
   input logic [DATA_W-1:0] port_ld_data_i
);

   // Tracks whether the open request has been accepted by the port
   logic acked;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)                          acked <= 1'b0;
      else if (!port_addr_vld_o || kill_i)  acked <= 1'b0;
      else if (port_addr_ack_i)             acked <= 1'b1;
   end

   a_r1_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(port_ld_req_o && port_st_req_o));

   a_r1_kind_with_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_ld_req_o || port_st_req_o) == port_addr_vld_o);

   a_r2_issue_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(port_addr_vld_o) |-> !$past(port_busy_i));

   a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_addr_vld_o && $past(port_addr_vld_o)) |-> $stable(port_addr_o));

   a_r4_exc_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_addr_vld_o && !acked && port_addr_exc_i && !kill_i)
      |=> (done_o && exc_o && !port_addr_vld_o));

   a_r5_load_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_ld_req_o && acked && port_ld_vld_i && !kill_i)
      |=> (done_o && !exc_o && rdata_o == $past(port_ld_data_i)));

   a_r6_store_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_st_vld_o |-> ($past(port_addr_ack_i) && port_st_req_o));

   a_r6_store_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_st_vld_o |=> !port_st_vld_o);

   a_r8_kill_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kill_i |=> (!port_addr_vld_o && !port_st_vld_o && !done_o && cmd_ready_o));

   a_r10_done_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!port_addr_vld_o && !port_ld_req_o && !port_st_req_o && !port_st_vld_o));

   a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

endmodule

bind ldst_req_seq ldst_req_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .kill_i          (kill_i),
   .cmd_ready_o     (cmd_ready_o),
   .done_o          (done_o),
   .exc_o           (exc_o),
   .rdata_o         (rdata_o),
   .port_ld_req_o   (port_ld_req_o),
   .port_st_req_o   (port_st_req_o),
   .port_addr_vld_o (port_addr_vld_o),
   .port_addr_o     (port_addr_o),
   .port_st_vld_o   (port_st_vld_o),
   .port_busy_i     (port_busy_i),
   .port_addr_ack_i (port_addr_ack_i),
   .port_addr_exc_i (port_addr_exc_i),
   .port_ld_vld_i   (port_ld_vld_i),
   .port_ld_data_i  (port_ld_data_i)
);

// File: tb/sim_ldst_req_seq.sv
`timescale 1ns/1ps
module sim_ldst_req_seq;

   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          kill = 1'b0;
   logic          start = 1'b0;
   logic          cmd_store = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          cmd_ready, done, exc;
   logic [DW-1:0] rdata;
   logic          ld_req, st_req, addr_vld, st_vld;
   logic [AW-1:0] paddr;
   logic [DW-1:0] st_data;
   logic          rsp_busy = 1'b0, ext_busy = 1'b0;
   logic          ack = 1'b0, aexc = 1'b0, ldv = 1'b0;
   logic [DW-1:0] ld_data = '0;
   logic          busy;

   assign busy = rsp_busy | ext_busy;

   always #5 clk = ~clk;

   ldst_req_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .kill_i(kill),
      .cmd_start_i(start), .cmd_store_i(cmd_store), .cmd_addr_i(cmd_addr),
      .cmd_wdata_i(cmd_wdata), .cmd_ready_o(cmd_ready), .done_o(done),
      .exc_o(exc), .rdata_o(rdata),
      .port_ld_req_o(ld_req), .port_st_req_o(st_req),
      .port_addr_vld_o(addr_vld), .port_addr_o(paddr),
      .port_st_vld_o(st_vld), .port_st_data_o(st_data),
      .port_busy_i(busy), .port_addr_ack_i(ack), .port_addr_exc_i(aexc),
      .port_ld_vld_i(ldv), .port_ld_data_i(ld_data)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- port model ----------------
   typedef enum int {M_IDLE, M_ACK, M_LD, M_ST, M_STDROP, M_END} mstate_e;
   mstate_e       m = M_IDLE;
   int            cnt = 0;
   int            cfg_ack_d = 0, cfg_ld_d = 0;
   bit            cfg_exc = 0;
   logic [AW-1:0] rec_addr = '0;
   bit            rec_st = 0;
   bit            req_prev = 0;
   bit            f_r1 = 0, f_r2 = 0, f_r3 = 0, f_r6 = 0;
   logic [DW-1:0] mem [16];

   initial for (int i = 0; i < 16; i++) mem[i] = '0;

   always @(negedge clk) begin
      bit req_now;
      req_now = ld_req | st_req;
      if (!rst_n || kill) begin
         m = M_IDLE; rsp_busy = 0; ack = 0; aexc = 0; ldv = 0;
         req_prev = req_now;
      end else begin
         if (ld_req && st_req) f_r1 = 1;
         if (req_now && !req_prev && busy) f_r2 = 1;
         req_prev = req_now;
         if (st_vld && m != M_ST) f_r6 = 1;
         ack = 0; aexc = 0; ldv = 0;
         if (m == M_ACK || m == M_LD || m == M_ST || m == M_STDROP)
            if (!addr_vld || paddr != rec_addr) f_r3 = 1;
         case (m)
            M_IDLE: if (req_now) begin
               if (!addr_vld) f_r3 = 1;
               rec_addr = paddr; rec_st = st_req;
               rsp_busy = 1; cnt = cfg_ack_d; m = M_ACK;
            end
            M_ACK: begin
               if (cnt == 0) begin
                  if (cfg_exc) begin aexc = 1; rsp_busy = 0; m = M_END; end
                  else begin ack = 1; cnt = cfg_ld_d; m = rec_st ? M_ST : M_LD; end
               end else cnt--;
            end
            M_LD: begin
               if (cnt == 0) begin
                  ldv = 1; ld_data = mem[rec_addr[3:0]]; rsp_busy = 0; m = M_END;
               end else cnt--;
            end
            M_ST: if (st_vld) begin mem[rec_addr[3:0]] = st_data; m = M_STDROP; end
            M_STDROP: begin rsp_busy = 0; m = M_END; end
            M_END: if (!req_now) m = M_IDLE;
            default: m = M_IDLE;
         endcase
      end
   end

   // ---------------- command driver ----------------
   task automatic do_op(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input int ad, input int ld, input bit ex, input int ext, input int poke,
                        output int n, output bit got_done, output bit got_exc,
                        output logic [DW-1:0] got_rd);
      @(negedge clk);
      cfg_ack_d = ad; cfg_ld_d = ld; cfg_exc = ex;
      cmd_store = st; cmd_addr = a; cmd_wdata = wd; start = 1;
      if (ext > 0) ext_busy = 1;
      n = 0; got_done = 0; got_exc = 0; got_rd = '0;
      while (n < 300 && !got_done) begin
         @(posedge clk); n++;
         @(negedge clk);
         start = 0;
         if (ext > 0 && n == ext) ext_busy = 0;
         if (poke > 0 && n == poke) begin
            start = 1; cmd_store = !st; cmd_addr = a ^ 8'h0F; cmd_wdata = ~wd;
         end
         if (done) begin got_done = 1; got_exc = exc; got_rd = rdata; end
      end
      // R10: done lasts one cycle and the sequencer is idle again
      @(negedge clk);
      chk(!done && cmd_ready, "R10 single-cycle done", {62'd0, done, cmd_ready}, 64'd1);
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return DW'((a * 16'h1111) ^ 16'h5A3C);
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      int n; bit gd, ge; logic [DW-1:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(cmd_ready && !done && !exc && !addr_vld && !ld_req && !st_req && !st_vld && rdata == 0,
          "R10 reset state", {57'd0, cmd_ready, done, exc, addr_vld, ld_req, st_req, st_vld}, 64'h40);

      // store sweep (R1, R6, R7, R11)
      for (int a = 0; a < 16; a++) begin
         do_op(1, AW'(8'h40 + a), pat(a), a % 3, 0, 0, 0, 0, n, gd, ge, rd);
         chk(gd && !ge, "R7 store completes", {62'd0, gd, ge}, 64'd2);
         chk(n == 6 + a % 3, "R11 store latency", n, 6 + a % 3);
      end

      // load sweep (R5, R11)
      for (int a = 0; a < 16; a++) begin
         do_op(0, AW'(8'h90 + a), '0, (a + 1) % 3, a % 4, 0, 0, 0, n, gd, ge, rd);
         chk(gd && !ge && rd == pat(a), "R5 load data", rd, pat(a));
         chk(n == 5 + (a + 1) % 3 + a % 4, "R11 load latency", n, 5 + (a + 1) % 3 + a % 4);
      end

      // exceptions on stores and loads (R4)
      for (int d = 0; d < 3; d++) begin
         do_op(1, 8'h03, 16'hDEAD, d, 0, 1, 0, 0, n, gd, ge, rd);
         chk(gd && ge && rd == 0, "R4 store refused", {47'd0, gd, ge, rd}, {47'd0, 2'b11, 16'd0});
         chk(n == 4 + d, "R4 exception latency", n, 4 + d);
         do_op(0, 8'h05, '0, d, 0, 1, 0, 0, n, gd, ge, rd);
         chk(gd && ge && rd == 0, "R4 load refused", {47'd0, gd, ge, rd}, {47'd0, 2'b11, 16'd0});
      end
      do_op(0, 8'h03, '0, 0, 0, 0, 0, 0, n, gd, ge, rd);
      chk(rd == pat(3), "R4 refused store left memory", rd, pat(3));

      // port held busy by another party before issue (R2)
      do_op(0, 8'h07, '0, 1, 2, 0, 4, 0, n, gd, ge, rd);
      chk(gd && rd == pat(7), "R2 load after busy", rd, pat(7));
      chk(n == 5 + 1 + 2 + 3, "R2 issue waits for busy low", n, 11);
      do_op(1, 8'h0A, 16'h1234, 0, 0, 0, 5, 0, n, gd, ge, rd);
      chk(n == 6 + 4, "R2 store waits for busy low", n, 10);

      // start strobes during a request are ignored (R9)
      do_op(0, 8'h0C, 16'h7777, 1, 6, 0, 0, 3, n, gd, ge, rd);
      chk(gd && !ge && rd == pat(12), "R9 load unaffected by start", rd, pat(12));
      chk(n == 5 + 1 + 6, "R9 load timing unaffected", n, 12);
      do_op(1, 8'h0E, 16'hC0DE, 2, 0, 0, 0, 4, n, gd, ge, rd);
      do_op(0, 8'h01, '0, 0, 0, 0, 0, 0, n, gd, ge, rd);
      chk(rd == pat(1), "R9 poked address untouched", rd, pat(1));
      do_op(0, 8'h0E, '0, 0, 0, 0, 0, 0, n, gd, ge, rd);
      chk(rd == 16'hC0DE, "R9 store data kept", rd, 16'hC0DE);

      // kill during a long load wait (R8)
      @(negedge clk);
      cfg_ack_d = 0; cfg_ld_d = 30; cfg_exc = 0;
      cmd_store = 0; cmd_addr = 8'h27; start = 1;
      @(posedge clk); @(negedge clk); start = 0;
      repeat (4) @(negedge clk);
      chk(addr_vld && ld_req, "R8 load open before kill", {62'd0, addr_vld, ld_req}, 64'd3);
      kill = 1;
      @(negedge clk);
      chk(!addr_vld && !ld_req && !st_req && !st_vld && !done && cmd_ready,
          "R8 lines idle after kill", {58'd0, addr_vld, ld_req, st_req, st_vld, done, cmd_ready}, 64'd1);
      @(negedge clk); kill = 0;
      begin
         bit saw = 0;
         for (int i = 0; i < 40; i++) begin @(negedge clk); if (done || addr_vld) saw = 1; end
         chk(!saw, "R8 no done for killed request", saw, 0);
      end
      do_op(0, 8'h02, '0, 0, 1, 0, 0, 0, n, gd, ge, rd);
      chk(gd && rd == pat(2) && n == 6, "R8 recovery after kill", {32'(n), 16'd0, rd}, {32'd6, 16'd0, pat(2)});

      // protocol observations gathered by the port model
      chk(!f_r1, "R1 both request lines high", f_r1, 0);
      chk(!f_r2, "R2 request raised while busy", f_r2, 0);
      chk(!f_r3, "R3 address not held", f_r3, 0);
      chk(!f_r6, "R6 store pulse outside window", f_r6, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule